// File: doc/BRIEF.md
# Six-Channel Interval Timer Bank

This block holds six independent 32-bit up-counters, numbered 1 to 6, behind a simple word-addressed register port. Each counter is started, stopped and cleared through its own control word. It counts on one of two external tick-enable inputs, and it can halve that tick rate. A compare word sets the point where the counter raises a match.

Each counter runs in one of three modes. In one-shot mode it stops at the compare value and turns itself off. In repeat mode it reloads zero, which gives a period of `compare` ticks. In free-run mode it counts on and raises no match.

Every match sets a pending bit. A shared enable mask decides which pending bits drive the single level interrupt output. Software clears pending bits by writing ones to the acknowledge word.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every register reads zero, every counter is stopped at zero and `irq` is low.
- R2: Register map for timer n (1 to 6):
  - control word at 0x10*n
  - tick-select word at 0x10*n+0x4
  - counter at 0x10*n+0x8, read-only; writes to it are ignored
  - compare word at 0x10*n+0xC

  The interrupt enable mask is at 0x00 and the pending/acknowledge word is at 0x08. In both, bit n-1 belongs to timer n.
- R3: Control word fields:
  - bit 0 is the run enable.
  - bits 5:4 hold the mode: 0 one-shot, 1 repeat, 3 free-run. The value 2 behaves as free-run.
  - bit 1 is a clear strobe. Writing 1 to it zeroes the counter and the divider phase in that cycle, and the bit always reads back 0.
- R4: While enabled, a counter adds one per selected tick.
  - Tick-select bit 4 picks the source: 0 is `fast_tick`, 1 is `slow_tick`.
  - Tick-select bit 0 set to 1 means only every second selected tick counts.
  - Ticks on the unselected input have no effect.
- R5: In repeat mode, a tick that would bring the counter to the compare value reloads zero instead and raises a match.
- R6: In one-shot mode, a tick that brings the counter to the compare value leaves it there, raises a match and clears the run enable. Further ticks leave the counter unchanged.
- R7: In free-run mode, passing the compare value neither raises a match nor alters counting.
- R8: Pending bits:
  - A match sets the timer's pending bit whatever the enable mask holds.
  - Writing 1 to a pending bit at 0x08 clears it. Writing 0 leaves it unchanged.
  - A match in the same cycle as its acknowledge leaves the bit set.
- R9: `irq` is high exactly while some pending bit has its enable mask bit set.
- R10: Reads of addresses that are not word-aligned or not in the map return zero, and writes to them change nothing.
- R11: Timers are independent: ticks and writes aimed at one timer leave the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_tick | input | 1 | Fast tick enable, one cycle per tick |
| slow_tick | input | 1 | Slow tick enable, one cycle per tick |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, any enabled pending bit |

## Verification
The checker assumes that tick enables and bus signals are synchronous to `clk` and stable around the rising edge. It also assumes that a write lasts exactly the cycles in which `bus_we` is high, so every acknowledge or control write takes effect on one edge. The bench drives all inputs on the falling edge and holds each tick or write strobe for one full cycle. It pulses ticks one at a time, so the counter value and the match cycle are known exactly. One case deliberately lines a tick that causes a match up with an acknowledge write in the same cycle.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_FREE = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_TSEL = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CMP  = 2'd3;
endpackage

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              wr_ctrl,
  input  logic              wr_tsel,
  input  logic              wr_cmp,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_view,
  output logic [DATA_W-1:0] tsel_view,
  output logic [DATA_W-1:0] cnt_view,
  output logic [DATA_W-1:0] cmp_view,
  output logic              hit
);
  logic              run_q, run_d;
  tmr_mode_e         mode_q, mode_d;
  logic              src_q, src_d;
  logic              half_q, half_d;
  logic              phase_q, phase_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] cmp_q, cmp_d;
  logic              raw_tick, step;
  logic [DATA_W-1:0] cnt_inc;

  always_comb begin
    raw_tick = src_q ? slow_tick : fast_tick;
    step     = run_q && raw_tick && (!half_q || phase_q);
    cnt_inc  = cnt_q + DATA_W'(1);
    hit      = step && (mode_q == MODE_ONCE || mode_q == MODE_LOOP)
               && (cnt_inc == cmp_q);
  end

  always_comb begin
    run_d   = run_q;
    mode_d  = mode_q;
    src_d   = src_q;
    half_d  = half_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cmp_d   = cmp_q;
    if (run_q && raw_tick && half_q) phase_d = ~phase_q;
    if (step) begin
      cnt_d = cnt_inc;
      if (hit) begin
        if (mode_q == MODE_LOOP) cnt_d = '0;
        else                     run_d = 1'b0;
      end
    end
    if (wr_ctrl) begin
      run_d  = wdata[0];
      mode_d = tmr_mode_e'(wdata[5:4]);
      if (wdata[1]) begin
        cnt_d   = '0;
        phase_d = 1'b0;
      end
    end
    if (wr_tsel) begin
      src_d  = wdata[4];
      half_d = wdata[0];
    end
    if (wr_cmp) cmp_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mode_q  <= MODE_ONCE;
      src_q   <= 1'b0;
      half_q  <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      cmp_q   <= '0;
    end else begin
      run_q   <= run_d;
      mode_q  <= mode_d;
      src_q   <= src_d;
      half_q  <= half_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      cmp_q   <= cmp_d;
    end
  end

  assign ctrl_view = {{(DATA_W-6){1'b0}}, mode_q, 3'b000, run_q};
  assign tsel_view = {{(DATA_W-5){1'b0}}, src_q, 3'b000, half_q};
  assign cnt_view  = cnt_q;
  assign cmp_view  = cmp_q;
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
  parameter int NT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mask,
  input  logic          wr_ack,
  input  logic [NT-1:0] wbits,
  input  logic [NT-1:0] hit,
  output logic [NT-1:0] mask_q,
  output logic [NT-1:0] pend_q,
  output logic          irq
);
  logic [NT-1:0] mask_d, pend_d, ack_bits;

  always_comb begin
    ack_bits = wr_ack ? wbits : '0;
    mask_d   = wr_mask ? wbits : mask_q;
    pend_d   = (pend_q & ~ack_bits) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign irq = |(pend_q & mask_q);
endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import gpt_pkg::*;
#(
  parameter int NUM_TIMERS = 6,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int SEL_W = ADDR_W - 4;

  logic [SEL_W-1:0]  sel;
  logic [1:0]        rsel;
  logic              aligned;
  logic [NUM_TIMERS-1:0] hit_vec, mask_vec, pend_vec;
  logic [DATA_W-1:0] ctrl_v [NUM_TIMERS];
  logic [DATA_W-1:0] tsel_v [NUM_TIMERS];
  logic [DATA_W-1:0] cnt_v  [NUM_TIMERS];
  logic [DATA_W-1:0] cmp_v  [NUM_TIMERS];
  logic              glob_wr;

  assign sel     = bus_addr[ADDR_W-1:4];
  assign rsel    = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign glob_wr = bus_we && aligned && (sel == '0);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
    logic hit_me;
    assign hit_me = bus_we && aligned && (sel == SEL_W'(i + 1));
    gpt_channel #(.DATA_W(DATA_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .wr_ctrl   (hit_me && rsel == REG_CTRL),
      .wr_tsel   (hit_me && rsel == REG_TSEL),
      .wr_cmp    (hit_me && rsel == REG_CMP),
      .wdata     (bus_wdata),
      .ctrl_view (ctrl_v[i]),
      .tsel_view (tsel_v[i]),
      .cnt_view  (cnt_v[i]),
      .cmp_view  (cmp_v[i]),
      .hit       (hit_vec[i])
    );
  end

  gpt_irq #(.NT(NUM_TIMERS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (glob_wr && rsel == 2'd0),
    .wr_ack  (glob_wr && rsel == 2'd2),
    .wbits   (bus_wdata[NUM_TIMERS-1:0]),
    .hit     (hit_vec),
    .mask_q  (mask_vec),
    .pend_q  (pend_vec),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (sel == '0) begin
        if (rsel == 2'd0) bus_rdata = {{(DATA_W-NUM_TIMERS){1'b0}}, mask_vec};
        if (rsel == 2'd2) bus_rdata = {{(DATA_W-NUM_TIMERS){1'b0}}, pend_vec};
      end
      for (int i = 0; i < NUM_TIMERS; i++) begin
        if (sel == SEL_W'(i + 1)) begin
          case (rsel)
            REG_CTRL: bus_rdata = ctrl_v[i];
            REG_TSEL: bus_rdata = tsel_v[i];
            REG_CNT:  bus_rdata = cnt_v[i];
            default:  bus_rdata = cmp_v[i];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/gp_timer_bank_chk.sv
module gp_timer_bank_chk #(
  parameter int NUM_TIMERS = 6,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [NUM_TIMERS-1:0] wbits,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [NUM_TIMERS-1:0] hit_vec,
  input logic [NUM_TIMERS-1:0] pend_vec,
  input logic                  irq
);
  logic mapped;
  int   tnum;
  always_comb begin
    tnum   = int'(bus_addr) / 16;
    mapped = (bus_addr[1:0] == 2'b00) &&
             ((bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(8)) ||
              (tnum >= 1 && tnum <= NUM_TIMERS));
  end

  // R8: a pending bit only appears after a match of that timer
  a_r8_pend_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & ~$past(pend_vec) & ~$past(hit_vec)) == '0));

  // R8: a match is never lost, even with an acknowledge in the same cycle
  a_r8_match_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((pend_vec & $past(hit_vec)) == $past(hit_vec)));

  // R8: an acknowledged bit without a new match is clear afterwards
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8)) |=>
      ((pend_vec & $past(wbits) & ~$past(hit_vec)) == '0));

  // R9: the interrupt needs some pending bit
  a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_vec != '0));

  // R10: unmapped addresses read zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == '0));
endmodule

bind gp_timer_bank gp_timer_bank_chk #(
  .NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .wbits     (bus_wdata[NUM_TIMERS-1:0]),
  .bus_rdata (bus_rdata),
  .hit_vec   (hit_vec),
  .pend_vec  (pend_vec),
  .irq       (irq)
);

// File: tb/gp_timer_bank_bench.sv
`timescale 1ns/1ps
module gp_timer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_tick = 1'b0;
  logic        slow_tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gp_timer_bank u_gp_timer_bank (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; fast_tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; fast_tick = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input bit slow, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (slow) slow_tick = 1'b1; else fast_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0; fast_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    rd_chk("R1 mask", 8'h00, 0);
    rd_chk("R1 pend", 8'h08, 0);
    rd_chk("R1 ctrl1", 8'h10, 0);
    rd_chk("R1 cnt1", 8'h18, 0);
    pulse(0, 2);
    rd_chk("R1 cnt1 stopped", 8'h18, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_ticks();
    wr(8'h14, 32'h0);
    wr(8'h10, 32'h31);
    pulse(0, 5);
    rd_chk("R4 fast count", 8'h18, 5);
    pulse(1, 3);
    rd_chk("R4 slow ignored", 8'h18, 5);
    wr(8'h14, 32'h10);
    pulse(1, 2);
    rd_chk("R4 slow count", 8'h18, 7);
    pulse(0, 2);
    rd_chk("R4 fast ignored", 8'h18, 7);
    wr(8'h14, 32'h11);
    rd_chk("R2 tsel readback", 8'h14, 32'h11);
    pulse(1, 4);
    rd_chk("R4 halved", 8'h18, 9);
    wr(8'h10, 32'h33);
    rd_chk("R3 clear", 8'h18, 0);
    rd_chk("R3 strobe reads 0", 8'h10, 32'h31);
    wr(8'h10, 32'h0);
    pulse(1, 2);
    rd_chk("R3 disabled holds", 8'h18, 0);
  endtask

  task automatic t_repeat();
    wr(8'h00, 32'h2);
    wr(8'h2C, 32'd3);
    wr(8'h20, 32'h11);
    pulse(0, 2);
    rd_chk("R5 cnt before match", 8'h28, 2);
    rd_chk("R5 no pend yet", 8'h08, 0);
    pulse(0, 1);
    rd_chk("R5 reload", 8'h28, 0);
    rd_chk("R5 pend", 8'h08, 32'h2);
    check("R9 irq on", {31'b0, irq}, 1);
    pulse(0, 3);
    rd_chk("R5 period", 8'h28, 0);
    wr(8'h08, 32'h2);
    rd_chk("R8 ack", 8'h08, 0);
    check("R9 irq off", {31'b0, irq}, 0);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_oneshot();
    wr(8'h3C, 32'd3);
    wr(8'h30, 32'h01);
    pulse(0, 3);
    rd_chk("R6 stop at cmp", 8'h38, 3);
    rd_chk("R6 enable cleared", 8'h30, 0);
    rd_chk("R8 pend unmasked", 8'h08, 32'h4);
    check("R9 masked off", {31'b0, irq}, 0);
    pulse(0, 2);
    rd_chk("R6 stays", 8'h38, 3);
    wr(8'h00, 32'h4);
    check("R9 mask on", {31'b0, irq}, 1);
    wr(8'h08, 32'h0);
    rd_chk("R8 zero ack", 8'h08, 32'h4);
    wr(8'h08, 32'h3F);
    rd_chk("R8 ack all", 8'h08, 0);
    check("R9 off after ack", {31'b0, irq}, 0);
  endtask

  task automatic t_free();
    wr(8'h4C, 32'd3);
    wr(8'h40, 32'h31);
    pulse(0, 6);
    rd_chk("R7 passes cmp", 8'h48, 6);
    rd_chk("R7 no pend", 8'h08, 0);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_same_cycle();
    wr(8'h5C, 32'd2);
    wr(8'h50, 32'h11);
    pulse(0, 2);
    rd_chk("R8 pend t5", 8'h08, 32'h10);
    pulse(0, 1);
    wr_tick(8'h08, 32'h10);
    rd_chk("R8 match beats ack", 8'h08, 32'h10);
    rd_chk("R5 reload t5", 8'h58, 0);
    wr(8'h08, 32'h10);
    rd_chk("R8 later ack", 8'h08, 0);
    wr(8'h50, 32'h0);
    rd_chk("R11 t4 untouched", 8'h48, 6);
    rd_chk("R11 t3 untouched", 8'h38, 3);
  endtask

  task automatic t_map();
    wr(8'h6C, 32'hDEADBEEF);
    rd_chk("R2 cmp6", 8'h6C, 32'hDEADBEEF);
    wr(8'h68, 32'h55);
    rd_chk("R2 cnt read-only", 8'h68, 0);
    wr(8'h6D, 32'h1);
    rd_chk("R10 misaligned write", 8'h6C, 32'hDEADBEEF);
    rd_chk("R10 hole 04", 8'h04, 0);
    rd_chk("R10 hole 0C", 8'h0C, 0);
    rd_chk("R10 past last", 8'h70, 0);
    rd_chk("R10 misaligned read", 8'h6D, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ticks();
    t_repeat();
    t_oneshot();
    t_free();
    t_same_cycle();
    t_map();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule